// File: doc/BRIEF.md
# Scrambled Xorshift32 Random Word Generator

This block produces a stream of 32-bit pseudo-random words. A 32-bit state register moves forward through a three-step xorshift recurrence. The state itself never reaches the output. A copy of the state from before the step passes through two rotate-and-add stages, and that result is XORed with the state from after the step.

A client pulses a step request to receive one word. The word appears on the output one clock later, together with a single-cycle valid pulse. A seed can be loaded at any time. A zero seed is replaced by 1, because the recurrence would otherwise stay at zero.

Top module: `xs32_scramble_gen`

## Requirements
- R1: A synchronous reset sets the state to 1, clears `rnd_word` to 0 and clears `rnd_valid`.
- R2: One step updates the state `s` in this order: `s ^= s<<13`, then `s ^= s>>17`, then `s ^= s<<5`, on 32 bits.
- R3: The output word is formed from `c`, the state before the step, as follows: `x = c + rotl(c,18)`, then `y = x + (rotl(x,7) ^ rotl(x,11))`, then the word is `y ^` the state after the step. All additions wrap modulo 2^32.
- R4: A step request without a load in cycle n updates `rnd_word` and raises `rnd_valid` in cycle n+1. In all other cycles `rnd_valid` is low and `rnd_word` keeps its value.
- R5: Each step request advances the state exactly once. Idle cycles between requests do not change the sequence.
- R6: A load request with a non-zero value makes that value the state. The next step's output is computed from it.
- R7: A load request with value 0 sets the state to 1.
- R8: A load request takes priority over a step request in the same cycle. The step is ignored, `rnd_valid` stays low and `rnd_word` is unchanged.
- R9: The state is never zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_req | input | 1 | Load `load_val` into the state |
| load_val | input | 32 | Seed value |
| step_req | input | 1 | Request one output word |
| rnd_word | output | 32 | Last generated word |
| rnd_valid | output | 1 | One-cycle pulse when `rnd_word` is new |

## Verification
The assertions assume that reset is asserted at the first clock edge. Before that edge the state is unknown, and a non-zero state can only be guaranteed from reset onward. The bench holds reset across the first edges. It changes the request and seed inputs only on falling edges, so every request is seen as one clean cycle-wide level. It also drives simultaneous load and step requests on purpose, to exercise the priority rule.

// File: rtl/xs32_scramble_gen.sv
module xs32_scramble_gen #(
  parameter int W     = 32,
  parameter int SH_A  = 13,
  parameter int SH_B  = 17,
  parameter int SH_C  = 5,
  parameter int ROT_A = 18,
  parameter int ROT_B = 7,
  parameter int ROT_C = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_req,
  input  logic [W-1:0] load_val,
  input  logic         step_req,
  output logic [W-1:0] rnd_word,
  output logic         rnd_valid
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    return (x << n) | (x >> (W - n));
  endfunction

  logic [W-1:0] state, t1, t2, nxt, mix1, mix2, seed_fix;

  assign t1   = state ^ (state << SH_A);
  assign t2   = t1 ^ (t1 >> SH_B);
  assign nxt  = t2 ^ (t2 << SH_C);
  assign mix1 = state + rotl(state, ROT_A);
  assign mix2 = mix1 + (rotl(mix1, ROT_B) ^ rotl(mix1, ROT_C));
  assign seed_fix = (load_val == '0) ? ONE : load_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ONE;
      rnd_word  <= '0;
      rnd_valid <= 1'b0;
    end else if (load_req) begin
      state     <= seed_fix;
      rnd_valid <= 1'b0;
    end else if (step_req) begin
      state     <= nxt;
      rnd_word  <= mix2 ^ nxt;
      rnd_valid <= 1'b1;
    end else begin
      rnd_valid <= 1'b0;
    end
  end

  assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  assert_valid_after_step_R4: assert property (@(posedge clk) disable iff (rst)
    (step_req && !load_req) |=> rnd_valid);

  assert_word_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!step_req || load_req) |=> ($stable(rnd_word) && !rnd_valid));

  assert_load_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    (load_req && load_val != '0) |=> state == $past(load_val));

  assert_load_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (load_req && load_val == '0) |=> state == ONE);

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (load_req && step_req) |=> !rnd_valid);
endmodule

// File: tb/xs32_scramble_gen_tb.sv
module xs32_scramble_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_req = 1'b0;
  logic [31:0] load_val = '0;
  logic step_req = 1'b0;
  logic [31:0] rnd_word;
  logic rnd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] ms;

  always #4 clk = ~clk;

  xs32_scramble_gen u_dut (
    .clk(clk), .rst(rst), .load_req(load_req), .load_val(load_val),
    .step_req(step_req), .rnd_word(rnd_word), .rnd_valid(rnd_valid)
  );

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] mstep(inout logic [31:0] s);
    logic [31:0] c;
    c = s;
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    c = c + rol(c, 18);
    c = c + (rol(c, 7) ^ rol(c, 11));
    return c ^ s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_once(input string req);
    logic [31:0] e;
    @(negedge clk) step_req = 1'b1;
    @(negedge clk) step_req = 1'b0;
    e = mstep(ms);
    chk(req, rnd_word, e);
    chk({req, " valid"}, {31'b0, rnd_valid}, 32'd1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ms = 32'd1;
    chk("R1 word", rnd_word, 32'd0);
    chk("R1 valid", {31'b0, rnd_valid}, 32'd0);
  endtask

  task automatic t_burst;
    logic [31:0] e;
    @(negedge clk) step_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      e = mstep(ms);
      chk("R2 R3 burst", rnd_word, e);
      chk("R4 burst valid", {31'b0, rnd_valid}, 32'd1);
    end
    step_req = 1'b0;
  endtask

  task automatic t_gaps;
    logic [31:0] held;
    @(negedge clk);
    held = rnd_word;
    repeat (4) @(negedge clk);
    chk("R4 idle valid", {31'b0, rnd_valid}, 32'd0);
    chk("R4 idle hold", rnd_word, held);
    step_once("R5 after gap");
    @(negedge clk);
    step_once("R5 second after gap");
  endtask

  task automatic t_seed;
    @(negedge clk) begin load_req = 1'b1; load_val = 32'hDEADBEEF; end
    @(negedge clk) load_req = 1'b0;
    ms = 32'hDEADBEEF;
    chk("R6 load valid", {31'b0, rnd_valid}, 32'd0);
    step_once("R6 seeded");
    step_once("R6 seeded 2");
  endtask

  task automatic t_zero_seed;
    @(negedge clk) begin load_req = 1'b1; load_val = 32'h0; end
    @(negedge clk) load_req = 1'b0;
    ms = 32'd1;
    step_once("R7 zero seed");
    step_once("R7 zero seed 2");
  endtask

  task automatic t_priority;
    logic [31:0] held;
    held = rnd_word;
    @(negedge clk) begin load_req = 1'b1; step_req = 1'b1; load_val = 32'h12345678; end
    @(negedge clk) begin load_req = 1'b0; step_req = 1'b0; end
    ms = 32'h12345678;
    chk("R8 valid low", {31'b0, rnd_valid}, 32'd0);
    chk("R8 word held", rnd_word, held);
    step_once("R8 seed used");
  endtask

  task automatic t_long;
    logic [31:0] e;
    int bad = 0;
    int zero = 0;
    @(negedge clk) step_req = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      e = mstep(ms);
      if (rnd_word !== e || rnd_valid !== 1'b1) bad++;
      if (ms == 0) zero++;
    end
    step_req = 1'b0;
    chk("R9 long run mismatches", bad, 0);
    chk("R9 model state zero count", zero, 0);
  endtask

  initial begin
    t_reset();
    step_once("R3 first from reset");
    t_burst();
    t_gaps();
    t_seed();
    t_zero_seed();
    t_priority();
    t_long();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule